// File: doc/BRIEF.md
# Blocked/Runnable Thread Scheduler

This block picks which resident thread a multithreaded core executes in each cycle. Resident thread IDs are in one of two places: the run rotation, an ordered queue of threads ready to execute, or the parked set, which holds threads waiting on something outside the pipeline (an outstanding load) or inside it (a long arithmetic operation). Each cycle the ID at the front of the rotation is issued. Unless the core stalls it, that ID goes back to the back of the rotation, so ready threads take turns with no bubble between them.

A stall in the same cycle as an issue parks the issued ID. A later wake event tagged with that ID puts it back at the back of the rotation. New threads enter through a launch port, which the block refuses once its residency limit is reached or when the ID is already resident. Thread state never moves. The block gives each issued ID a base address into one shared register file, so the core indexes the active thread's registers directly.

Top module: `thread_sched_core`

## Requirements
- R1: After reset no thread is resident, the rotation is empty and `issue_valid_o` is low.
- R2: `launch_accept_o` is high in the same cycle only when `launch_valid_i` is high, fewer than MAX_THREADS (default 48) IDs are resident and `launch_tid_i` is not already resident. A refused launch changes nothing.
- R3: An accepted launch appends its ID to the back of the rotation. From an empty rotation, that ID is issued in the next cycle.
- R4: In each cycle with `issue_valid_o` high, `issue_tid_o` is the front of the rotation. When `stall_i` is low, that ID goes back to the back of the rotation, so ready threads are issued in strict round-robin order.
- R5: `stall_i` high in a cycle with `issue_valid_o` high removes the issued ID from the rotation and parks it. A parked ID is never issued.
- R6: A wake (`wake_valid_i` with `wake_tid_i`) for a parked ID unparks it and appends it to the back of the rotation.
- R7: A wake for an ID that is not parked has no effect.
- R8: A stall and a wake in the same cycle are applied stall first. A wake naming the ID that is being parked in that cycle returns it straight to the back of the rotation.
- R9: When the rotation is empty, `issue_valid_o` is low and `stall_i` is ignored. `issue_valid_o` stays low until an accepted launch or a wake that hits a parked ID.
- R10: While `issue_valid_o` is high, `issue_base_o` equals `issue_tid_o` times REGS_PER_THREAD (default 32).
- R11: IDs appended in one cycle enter the rotation in this order: the recycled issued ID first, then the woken ID, then the launched ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall_i | input | 1 | The thread issued this cycle hits a dependency and must park |
| wake_valid_i | input | 1 | A dependency has cleared |
| wake_tid_i | input | TID_W | ID whose dependency cleared |
| launch_valid_i | input | 1 | Request to make a new thread resident |
| launch_tid_i | input | TID_W | ID of the new thread |
| launch_accept_o | output | 1 | The launch request of this cycle is taken |
| issue_valid_o | output | 1 | A thread is issued this cycle |
| issue_tid_o | output | TID_W | ID of the issued thread |
| issue_base_o | output | TID_W+clog2(REGS_PER_THREAD) | Register-file base of the issued thread |

## Verification
A corrupted rotation slot or pointer shows up within one full turn of the rotation: a wrong or repeated ID appears on `issue_tid_o`, or some ID never comes up. A stale parked bit shows up when its wake arrives. Either a woken thread never reappears, or a thread is issued twice per turn and the turn length differs from the number of ready threads. A wrong residency count shows first on `launch_accept_o` at the limit. Because every output is compared with a model in every cycle, each of these faults is reported in the first cycle the ports diverge.

// File: rtl/thread_sched_pkg.sv
package thread_sched_pkg;

   // Append lanes of the rotation, listed in the order they enter it
   localparam int LANES = 3;

   typedef enum logic [1:0] {
      LANE_RECYCLE = 2'd0,
      LANE_WAKE    = 2'd1,
      LANE_LAUNCH  = 2'd2
   } lane_e;

   // Modulo reduction for an index known to be below 2*depth
   function automatic int unsigned wrap_idx(input int unsigned idx,
                                            input int unsigned depth);
      return (idx >= depth) ? idx - depth : idx;
   endfunction

endpackage

// File: rtl/tsched_runq.sv
module tsched_runq
   import thread_sched_pkg::*;
#(
   parameter int DEPTH = 48,
   parameter int TID_W = 6
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        pop_i,
   input  logic [LANES-1:0]            push_vld_i,
   input  logic [LANES-1:0][TID_W-1:0] push_tid_i,
   output logic                        nonempty_o,
   output logic [TID_W-1:0]            head_tid_o
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic [TID_W-1:0]            slot_q [DEPTH];
   logic [PTR_W-1:0]            head_q;
   logic [CNT_W-1:0]            cnt_q;
   logic [PTR_W-1:0]            tail;
   logic [LANES-1:0][PTR_W-1:0] wr_idx;
   logic [CNT_W-1:0]            npush;

   assign tail = PTR_W'(wrap_idx(32'(head_q) + 32'(cnt_q), DEPTH));

   // Valid lanes take consecutive slots past the tail, in lane order
   always_comb begin
      int unsigned off;
      off = 0;
      for (int k = 0; k < LANES; k++) begin
         wr_idx[k] = PTR_W'(wrap_idx(32'(tail) + off, DEPTH));
         if (push_vld_i[k]) off = off + 1;
      end
      npush = CNT_W'(off);
   end

   always_ff @(posedge clk) begin
      for (int k = 0; k < LANES; k++) begin
         if (push_vld_i[k]) slot_q[wr_idx[k]] <= push_tid_i[k];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (pop_i) head_q <= PTR_W'(wrap_idx(32'(head_q) + 32'd1, DEPTH));
         cnt_q <= cnt_q - CNT_W'(pop_i) + npush;
      end
   end

   assign nonempty_o = (cnt_q != '0);
   assign head_tid_o = slot_q[head_q];

endmodule

// File: rtl/tsched_park.sv
module tsched_park #(
   parameter int TID_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             park_i,
   input  logic [TID_W-1:0] park_tid_i,
   input  logic             wake_i,
   input  logic [TID_W-1:0] wake_tid_i,
   output logic             wake_hit_o
);

   localparam int IDS = 1 << TID_W;

   logic [IDS-1:0] parked_q, parked_mid, parked_nx;

   // Parking is applied before the wake is looked up
   always_comb begin
      parked_mid = parked_q;
      if (park_i) parked_mid[park_tid_i] = 1'b1;
      wake_hit_o = wake_i && parked_mid[wake_tid_i];
      parked_nx  = parked_mid;
      if (wake_hit_o) parked_nx[wake_tid_i] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) parked_q <= '0;
      else        parked_q <= parked_nx;
   end

endmodule

// File: rtl/tsched_admit.sv
module tsched_admit #(
   parameter int MAX_THREADS = 48,
   parameter int TID_W       = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch_i,
   input  logic [TID_W-1:0] launch_tid_i,
   output logic             accept_o
);

   localparam int IDS   = 1 << TID_W;
   localparam int CNT_W = $clog2(MAX_THREADS + 1);

   logic [IDS-1:0]   resident_q;
   logic [CNT_W-1:0] count_q;

   assign accept_o = launch_i && (count_q < CNT_W'(MAX_THREADS))
                     && !resident_q[launch_tid_i];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resident_q <= '0;
         count_q    <= '0;
      end else if (accept_o) begin
         resident_q[launch_tid_i] <= 1'b1;
         count_q <= count_q + CNT_W'(1);
      end
   end

endmodule

// File: rtl/tsched_base.sv
module tsched_base #(
   parameter int TID_W           = 6,
   parameter int REGS_PER_THREAD = 32,
   localparam int SH             = $clog2(REGS_PER_THREAD),
   localparam int BASE_W         = TID_W + SH
) (
   input  logic [TID_W-1:0]  tid_i,
   output logic [BASE_W-1:0] base_o
);

   if ((1 << SH) == REGS_PER_THREAD) begin : g_shift
      assign base_o = BASE_W'(tid_i) << SH;
   end else begin : g_mult
      assign base_o = BASE_W'(tid_i) * BASE_W'(REGS_PER_THREAD);
   end

endmodule

// File: rtl/thread_sched_core.sv
module thread_sched_core
   import thread_sched_pkg::*;
#(
   parameter int MAX_THREADS     = 48,
   parameter int TID_W           = 6,
   parameter int REGS_PER_THREAD = 32,
   localparam int BASE_W         = TID_W + $clog2(REGS_PER_THREAD)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stall_i,
   input  logic              wake_valid_i,
   input  logic [TID_W-1:0]  wake_tid_i,
   input  logic              launch_valid_i,
   input  logic [TID_W-1:0]  launch_tid_i,
   output logic              launch_accept_o,
   output logic              issue_valid_o,
   output logic [TID_W-1:0]  issue_tid_o,
   output logic [BASE_W-1:0] issue_base_o
);

   if (MAX_THREADS > (1 << TID_W)) begin : g_bad_ids
      $error("MAX_THREADS exceeds the ID space of TID_W bits");
   end
   if (MAX_THREADS < LANES) begin : g_bad_depth
      $error("MAX_THREADS must be at least the number of append lanes");
   end
   if (REGS_PER_THREAD < 2) begin : g_bad_regs
      $error("REGS_PER_THREAD must be at least 2");
   end

   logic                        run_nonempty;
   logic [TID_W-1:0]            run_head;
   logic                        wake_hit;
   logic [LANES-1:0]            push_vld;
   logic [LANES-1:0][TID_W-1:0] push_tid;

   always_comb begin
      push_vld[LANE_RECYCLE] = run_nonempty && !stall_i;
      push_tid[LANE_RECYCLE] = run_head;
      push_vld[LANE_WAKE]    = wake_hit;
      push_tid[LANE_WAKE]    = wake_tid_i;
      push_vld[LANE_LAUNCH]  = launch_accept_o;
      push_tid[LANE_LAUNCH]  = launch_tid_i;
   end

   tsched_runq #(.DEPTH(MAX_THREADS), .TID_W(TID_W)) u_runq (
      .clk        (clk),
      .rst_n      (rst_n),
      .pop_i      (run_nonempty),
      .push_vld_i (push_vld),
      .push_tid_i (push_tid),
      .nonempty_o (run_nonempty),
      .head_tid_o (run_head)
   );

   tsched_park #(.TID_W(TID_W)) u_park (
      .clk        (clk),
      .rst_n      (rst_n),
      .park_i     (run_nonempty && stall_i),
      .park_tid_i (run_head),
      .wake_i     (wake_valid_i),
      .wake_tid_i (wake_tid_i),
      .wake_hit_o (wake_hit)
   );

   tsched_admit #(.MAX_THREADS(MAX_THREADS), .TID_W(TID_W)) u_admit (
      .clk          (clk),
      .rst_n        (rst_n),
      .launch_i     (launch_valid_i),
      .launch_tid_i (launch_tid_i),
      .accept_o     (launch_accept_o)
   );

   tsched_base #(.TID_W(TID_W), .REGS_PER_THREAD(REGS_PER_THREAD)) u_base (
      .tid_i  (run_head),
      .base_o (issue_base_o)
   );

   assign issue_valid_o = run_nonempty;
   assign issue_tid_o   = run_head;

endmodule

// File: rtl/thread_sched_core_chk.sv
module thread_sched_core_chk #(
   parameter int MAX_THREADS = 48,
   parameter int TID_W       = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             stall_i,
   input logic             wake_valid_i,
   input logic [TID_W-1:0] wake_tid_i,
   input logic             launch_valid_i,
   input logic [TID_W-1:0] launch_tid_i,
   input logic             launch_accept_o,
   input logic             issue_valid_o,
   input logic [TID_W-1:0] issue_tid_o
);

   localparam int IDS   = 1 << TID_W;
   localparam int CNT_W = $clog2(MAX_THREADS + 1);

   logic [CNT_W-1:0] taken_q;
   logic [IDS-1:0]   held_q, held_nx;

   always_comb begin
      held_nx = held_q;
      if (issue_valid_o && stall_i) held_nx[issue_tid_o] = 1'b1;
      if (wake_valid_i)             held_nx[wake_tid_i]  = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         taken_q <= '0;
         held_q  <= '0;
      end else begin
         held_q <= held_nx;
         if (launch_accept_o) taken_q <= taken_q + CNT_W'(1);
      end
   end

   p_full_refuse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (taken_q == CNT_W'(MAX_THREADS)) |-> !launch_accept_o);

   p_accept_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      launch_accept_o |-> launch_valid_i);

   p_first_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!issue_valid_o && launch_accept_o && !wake_valid_i)
      |=> (issue_valid_o && issue_tid_o == $past(launch_tid_i)));

   p_parked_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid_o |-> !held_q[issue_tid_o]);

   p_idle_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!issue_valid_o && !launch_accept_o && !wake_valid_i) |=> !issue_valid_o);

endmodule

bind thread_sched_core thread_sched_core_chk #(
   .MAX_THREADS (MAX_THREADS),
   .TID_W       (TID_W)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .stall_i         (stall_i),
   .wake_valid_i    (wake_valid_i),
   .wake_tid_i      (wake_tid_i),
   .launch_valid_i  (launch_valid_i),
   .launch_tid_i    (launch_tid_i),
   .launch_accept_o (launch_accept_o),
   .issue_valid_o   (issue_valid_o),
   .issue_tid_o     (issue_tid_o)
);

// File: tb/thread_sched_core_test.sv
`timescale 1ns/1ps
module thread_sched_core_test;

   localparam int MAXT   = 48;
   localparam int TW     = 6;
   localparam int REGS   = 32;
   localparam int BW     = TW + $clog2(REGS);
   localparam int NIDS   = 1 << TW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          stall = 1'b0;
   logic          wake_v = 1'b0;
   logic [TW-1:0] wake_t = '0;
   logic          launch_v = 1'b0;
   logic [TW-1:0] launch_t = '0;
   logic          accept;
   logic          issue_v;
   logic [TW-1:0] issue_t;
   logic [BW-1:0] issue_b;

   always #10 clk = ~clk;

   thread_sched_core #(.MAX_THREADS(MAXT), .TID_W(TW), .REGS_PER_THREAD(REGS)) uut (
      .clk             (clk),
      .rst_n           (rst_n),
      .stall_i         (stall),
      .wake_valid_i    (wake_v),
      .wake_tid_i      (wake_t),
      .launch_valid_i  (launch_v),
      .launch_tid_i    (launch_t),
      .launch_accept_o (accept),
      .issue_valid_o   (issue_v),
      .issue_tid_o     (issue_t),
      .issue_base_o    (issue_b)
   );

   // Behavioural reference state
   int runq[$];
   bit parked[NIDS];
   bit res[NIDS];
   int nres = 0;
   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;
   bit done = 0;

   task automatic check(input string req, input string what,
                        input longint act, input longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic step(input string req, input bit st, input bit wv, input int wt,
                       input bit lv, input int lt);
      bit exp_v, exp_acc;
      int t;
      @(negedge clk);
      stall = st; wake_v = wv; wake_t = TW'(wt); launch_v = lv; launch_t = TW'(lt);
      #1;
      exp_v   = runq.size() > 0;
      exp_acc = lv && (nres < MAXT) && !res[lt];
      check(req, "issue_valid", longint'(issue_v), longint'(exp_v));
      if (exp_v) begin
         check(req, "issue_tid", longint'(issue_t), longint'(runq[0]));
         check("R10", "issue_base", longint'(issue_b), longint'(runq[0] * REGS));
      end
      check(req, "launch_accept", longint'(accept), longint'(exp_acc));
      if (exp_v) begin
         t = runq.pop_front();
         if (st) parked[t] = 1'b1;
         else    runq.push_back(t);
      end
      if (wv && parked[wt]) begin
         parked[wt] = 1'b0;
         runq.push_back(wt);
      end
      if (exp_acc) begin
         res[lt] = 1'b1;
         nres++;
         runq.push_back(lt);
      end
   endtask

   task automatic idle(input string req, input int n);
      for (int i = 0; i < n; i++) step(req, 0, 0, 0, 0, 0);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         n_bad++;
         $display("watchdog expired at cycle %0d", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int h, h2, free_id;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      step("R1", 0, 0, 0, 0, 0);
      step("R9", 1, 0, 0, 0, 0);                 // stall while idle ignored

      step("R3", 0, 0, 0, 1, 5);
      step("R3", 0, 0, 0, 1, 9);
      step("R3", 0, 0, 0, 1, 2);
      idle("R4", 7);
      step("R2", 0, 0, 0, 1, 9);                 // duplicate refused
      idle("R4", 3);

      h = runq[0];
      step("R5", 1, 0, 0, 0, 0);
      idle("R5", 6);
      step("R7", 0, 1, runq[0], 0, 0);           // wake of a running ID
      idle("R7", 4);
      step("R6", 0, 1, h, 0, 0);
      idle("R6", 5);

      h = runq[0];
      step("R8", 1, 1, h, 0, 0);
      idle("R8", 5);

      h = runq[0];
      step("R11", 1, 0, 0, 0, 0);
      h2 = runq[0];
      step("R11", 0, 1, h, 1, 33);               // recycle, wake, launch together
      idle("R11", 6);

      while (runq.size() > 0) step("R9", 1, 0, 0, 0, 0);
      step("R9", 1, 0, 0, 0, 0);
      step("R9", 0, 1, 63, 0, 0);                // not parked: stays idle
      idle("R9", 2);
      step("R6", 0, 1, h2, 0, 0);
      step("R6", 0, 1, 5, 0, 0);
      idle("R6", 4);

      for (int i = 0; i < 2000; i++) begin
         bit st, wv, lv;
         st = ($urandom % 3) == 0;
         wv = ($urandom % 2) == 0;
         lv = ($urandom % 8) == 0;
         step("R4", st, wv, int'($urandom % 64), lv, int'($urandom % 64));
      end

      for (int id = 0; id < NIDS; id++) begin
         if (nres < MAXT && !res[id]) step("R2", 0, 0, 0, 1, id);
      end
      free_id = 0;
      for (int id = 0; id < NIDS; id++) if (!res[id]) free_id = id;
      step("R2", 0, 0, 0, 1, free_id);           // limit reached
      for (int id = 0; id < NIDS; id++) begin
         if (parked[id]) step("R6", 0, 1, id, 0, 0);
      end
      idle("R4", 100);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule